// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM array usable. After reset it first waits out a settling pause. It then runs a short burst of warm-up refresh cycles, and only after that does it report the array as ready. From then on a free-running interval timer produces one refresh demand per row slot. The demands are spaced so that every internal row is refreshed well inside its retention window.

Each refresh is a CAS-before-RAS cycle. The DRAM's internal row counter supplies the row, so no address is driven. The sequencer asks the access controller for the bus through a request line. When a grant arrives, it drives the row strobe, the column strobe and write enable itself. If the grant is late, demands are counted up to a small limit and then served one after another. The request stays high for the whole time the sequencer owns the strobes.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `req` and `init_done` are 0 and `ras_n`, `cas_n` and `we_n` are 1.
- R2: After reset is released, `req` stays low for exactly `PAUSE_CYCLES` clock edges and rises at the edge after that.
- R3: `init_done` rises only after exactly `WARMUP_REFRESHES` refresh cycles. It rises `PRECHARGE_CYCLES` clocks after the last warm-up row strobe has returned high, and it never falls again until reset.
- R4: In every refresh cycle, `cas_n` goes low exactly `SETUP_CYCLES` clocks before `ras_n` goes low. `cas_n` stays low for as long as `ras_n` is low.
- R5: `ras_n` stays low for exactly `RAS_LOW_CYCLES` clocks. `cas_n` returns high on the same edge. Both strobes then stay high for at least `PRECHARGE_CYCLES` clocks before `cas_n` falls again.
- R6: `we_n` is 1 whenever `ras_n` falls and throughout every refresh cycle.
- R7: A refresh cycle starts only on the clock after `gnt` was sampled 1 while `req` was 1. A request that is not granted stays asserted.
- R8: The first periodic refresh demand comes `INTERVAL_CYCLES` clocks after `init_done` rises. When the grant is held high, the column strobe falls one clock later. After that, refreshes start every `INTERVAL_CYCLES` clocks.
- R9: Ungranted demands are counted up to `MAX_PENDING`; further demands are dropped. Once the grant is given, the counted refreshes run back to back, with exactly `PRECHARGE_CYCLES` high strobe clocks between them.
- R10: A demand that arrives on the same clock that a pending refresh is started is kept. It is not lost.
- R11: `req` is high whenever `cas_n` or `ras_n` is low, and it falls once no demand is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt | input | 1 | Bus grant from the access controller |
| req | output | 1 | Bus request; held while a refresh is pending or running |
| init_done | output | 1 | Array initialised and ready for normal access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low, falls before the row strobe |
| we_n | output | 1 | Write enable, kept high during refresh |

## Verification
Two events can land on the same clock edge: the interval timer adding a demand to the pending count, and a grant removing one from it. The bench creates exactly this case. It withholds the grant across one timer expiry, then raises it on the clock just before the next expiry, so that the start and the new demand meet at one edge. The judgement is made at the ports. After a drain period, the number of column-strobe falls must equal the number of timer periods elapsed, less only the demands dropped on purpose in the saturation test.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYCLES     = 10000,
  parameter int WARMUP_REFRESHES = 8,
  parameter int INTERVAL_CYCLES  = 760,
  parameter int MAX_PENDING      = 4,
  parameter int SETUP_CYCLES     = 1,
  parameter int RAS_LOW_CYCLES   = 3,
  parameter int PRECHARGE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  output logic req,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int LONG1   = (RAS_LOW_CYCLES > PRECHARGE_CYCLES) ? RAS_LOW_CYCLES : PRECHARGE_CYCLES;
  localparam int LONG2   = (LONG1 > SETUP_CYCLES) ? LONG1 : SETUP_CYCLES;
  localparam int LONGEST = (PAUSE_CYCLES > LONG2) ? PAUSE_CYCLES : LONG2;
  localparam int CW  = $clog2(LONGEST + 1);
  localparam int WW  = $clog2(WARMUP_REFRESHES + 1);
  localparam int TW  = $clog2(INTERVAL_CYCLES);
  localparam int PNW = $clog2(MAX_PENDING + 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_SETUP, ST_ACT, ST_PRE} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [WW-1:0]  warm_left;
  logic [PNW-1:0] pend;
  logic [PNW:0]   pend_sum;
  logic [TW-1:0]  tmr;
  logic need, phase_end, start, tick;

  assign need      = init_done ? (pend != '0) : (warm_left != '0);
  assign phase_end = (cnt == '0);
  assign start     = gnt && need && (st == ST_IDLE || (st == ST_PRE && phase_end));
  assign tick      = init_done && (tmr == '0);

  assign req   = (st == ST_IDLE) ? need : (st != ST_PAUSE);
  assign ras_n = (st != ST_ACT);
  assign cas_n = !(st == ST_SETUP || st == ST_ACT);
  assign we_n  = 1'b1;

  always_comb begin
    pend_sum = {1'b0, pend};
    if (tick)
      pend_sum = pend_sum + 1'b1;
    if (start && init_done)
      pend_sum = pend_sum - 1'b1;
    if (pend_sum > (PNW+1)'(MAX_PENDING))
      pend_sum = (PNW+1)'(MAX_PENDING);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      cnt       <= CW'(PAUSE_CYCLES - 1);
      warm_left <= WW'(WARMUP_REFRESHES);
      pend      <= '0;
      tmr       <= TW'(INTERVAL_CYCLES - 1);
      init_done <= 1'b0;
    end else begin
      pend <= pend_sum[PNW-1:0];
      if (!init_done || tick) tmr <= TW'(INTERVAL_CYCLES - 1);
      else                    tmr <= tmr - 1'b1;
      if (start && !init_done) warm_left <= warm_left - 1'b1;

      unique case (st)
        ST_PAUSE: if (phase_end) st <= ST_IDLE;
                  else cnt <= cnt - 1'b1;
        ST_IDLE:  if (start) begin
                    st  <= ST_SETUP;
                    cnt <= CW'(SETUP_CYCLES - 1);
                  end
        ST_SETUP: if (phase_end) begin
                    st  <= ST_ACT;
                    cnt <= CW'(RAS_LOW_CYCLES - 1);
                  end else cnt <= cnt - 1'b1;
        ST_ACT:   if (phase_end) begin
                    st  <= ST_PRE;
                    cnt <= CW'(PRECHARGE_CYCLES - 1);
                  end else cnt <= cnt - 1'b1;
        ST_PRE:   if (phase_end) begin
                    if (!init_done && warm_left == '0) init_done <= 1'b1;
                    if (start) begin
                      st  <= ST_SETUP;
                      cnt <= CW'(SETUP_CYCLES - 1);
                    end else st <= ST_IDLE;
                  end else cnt <= cnt - 1'b1;
        default:  st <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_LOW_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic gnt,
  input logic req,
  input logic init_done,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4
  cas_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run == 16'(RAS_LOW_CYCLES)));

  // R6
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> we_n);

  // R7
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($past(gnt) && $past(req)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n || !ras_n) |-> req);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.RAS_LOW_CYCLES(RAS_LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .init_done(init_done),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  localparam int PAUSE = 20;
  localparam int WARM  = 8;
  localparam int IVL   = 40;
  localparam int MAXP  = 4;
  localparam int SETUP = 1;
  localparam int RLOW  = 3;
  localparam int PRE   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, init_done, ras_n, cas_n, we_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYCLES(PAUSE), .WARMUP_REFRESHES(WARM), .INTERVAL_CYCLES(IVL),
    .MAX_PENDING(MAXP), .SETUP_CYCLES(SETUP), .RAS_LOW_CYCLES(RLOW),
    .PRECHARGE_CYCLES(PRE)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ticks_at(input int cyc);
    return cyc / IVL;
  endfunction

  // port monitor
  bit prev_ras = 1, prev_cas = 1, prev_req = 0, prev_init = 0, cas_thru = 1;
  int setup_run = 0, low_run = 0, hi_run = 1000;
  int falls = 0, pfalls = 0, b2b = 0, c = 0, last_pfall = 0;
  bit const_grant = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_init) c++;
      if (prev_cas && !cas_n) begin
        chk(gnt && prev_req, "R7 start without grant", int'(gnt), 1);
        chk(hi_run >= PRE, "R5 precharge before cas", hi_run, PRE);
        if (hi_run == PRE) b2b++;
        falls++;
        if (init_done) begin
          if (pfalls == 0) chk(c == IVL + 1, "R8 first periodic refresh", c, IVL + 1);
          else if (const_grant) chk(c - last_pfall == IVL, "R8 refresh spacing", c - last_pfall, IVL);
          pfalls++;
          last_pfall = c;
        end
      end
      if (prev_ras && !ras_n) begin
        chk(!cas_n && setup_run == SETUP, "R4 cas lead", setup_run, SETUP);
        chk(we_n == 1'b1, "R6 we high", int'(we_n), 1);
        chk(req == 1'b1, "R11 req during cycle", int'(req), 1);
        cas_thru = 1;
      end
      if (!ras_n && cas_n) cas_thru = 0;
      if (!prev_ras && ras_n) begin
        chk(low_run == RLOW, "R5 ras low width", low_run, RLOW);
        chk(cas_n && cas_thru, "R4 cas held through ras low", int'(cas_thru), 1);
      end
      if (init_done && !prev_init) begin
        chk(falls == WARM, "R3 warm-up count", falls, WARM);
        chk(hi_run == PRE, "R3 ready after precharge", hi_run, PRE);
      end
      if (hi_run > PRE && prev_req && !gnt && ras_n && cas_n)
        chk(req == 1'b1, "R7 ungranted request held", int'(req), 1);

      setup_run = (!cas_n && ras_n) ? setup_run + 1 : 0;
      low_run   = !ras_n ? low_run + 1 : 0;
      if (!ras_n || !cas_n) hi_run = 0;
      else if (!prev_ras) hi_run = 1;
      else hi_run++;
      prev_ras = ras_n; prev_cas = cas_n; prev_req = req; prev_init = init_done;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wait_phase(input int ph);
    do begin @(negedge clk); #1; end while (c % IVL != ph);
  endtask

  initial begin
    int n, lost, f0, b0;
    void'($urandom(32'd4242));
    lost = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!req && !init_done, "R1 reset outputs low", int'(req) + int'(init_done), 0);
    chk(ras_n && cas_n && we_n, "R1 reset strobes high", int'(ras_n & cas_n & we_n), 1);
    #1 rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 1000);
    chk(n == PAUSE, "R2 pause length", n, PAUSE);

    #1 gnt = 1'b1;
    while (!init_done) @(negedge clk);
    #1;
    chk(falls == WARM, "R3 no extra warm-up", falls, WARM);
    chk(!req, "R11 req drops after warm-up", int'(req), 0);

    // R8: constant grant
    const_grant = 1;
    while (pfalls < 3) begin @(negedge clk); #1; end
    const_grant = 0;

    // R9: saturation and back-to-back drain
    wait_phase(10);
    f0 = pfalls; b0 = b2b;
    gnt = 1'b0;
    repeat (6 * IVL) @(negedge clk);
    #1 gnt = 1'b1;
    wait_phase(IVL - 1);
    chk(pfalls - f0 == MAXP, "R9 saturated pending served", pfalls - f0, MAXP);
    chk(b2b - b0 == MAXP - 1, "R9 back-to-back gaps", b2b - b0, MAXP - 1);
    chk(!req, "R11 req low after drain", int'(req), 0);
    lost += 6 - MAXP;
    chk(pfalls == ticks_at(c) - lost, "R9 total after saturation", pfalls, ticks_at(c) - lost);

    // R10: start coinciding with a new demand
    wait_phase(10);
    gnt = 1'b0;
    wait_phase(IVL - 1);
    wait_phase(IVL - 1);
    gnt = 1'b1;
    wait_phase(IVL - 1);
    chk(pfalls == ticks_at(c) - lost, "R10 coincident demand kept", pfalls, ticks_at(c) - lost);
    chk(!req, "R10 nothing left pending", int'(req), 0);

    // random grant pattern
    repeat (2000) begin
      @(negedge clk); #1;
      gnt = ($urandom % 4) != 0;
    end
    gnt = 1'b1;
    repeat (2 * IVL) @(negedge clk);
    wait_phase(IVL - 1);
    chk(pfalls == ticks_at(c) - lost, "R7 random grant total", pfalls, ticks_at(c) - lost);
    chk(init_done, "R3 ready stays high", int'(init_done), 1);
    finish_run();
  end
endmodule